// File: doc/BRIEF.md
# Three-Bit Circular Left Shifter with Mixed Storage Elements

This block holds a 3-bit pattern. On every rising clock edge the pattern moves one place toward the most significant end. The bit that leaves the top position comes back in at the bottom. A synchronous load writes a 3-bit seed, and the current pattern is always visible on the output.

The three storage cells are not all of one kind. The top and bottom bits sit in toggle cells, and the middle bit sits in a data cell. Each toggle cell is fed by excitation logic. That logic compares the bit's present value with the value the rotation wants next, and asserts the toggle input when the two differ. The middle cell takes its next value directly. Typical uses are a small ring sequencer or a phase-select pattern that a load seeds once and that then advances on its own.

Top module: `rotl_mixed`

## Requirements
- R1: While `rst` is high at a rising clock edge, the output `q` becomes 3'b000 after that edge.
- R2: When `load` is high at a rising edge (and `rst` is low), `q` equals `seed` after that edge. Load takes priority over rotation.
- R3: When `rst` and `load` are both low at a rising edge, the new `q[2]` equals the old `q[1]` and the new `q[1]` equals the old `q[0]`.
- R4: When `rst` and `load` are both low at a rising edge, the new `q[0]` equals the old `q[2]`.
- R5: Bit 2 is held in a toggle cell. Its toggle input is high exactly when old `q[2]` differs from old `q[1]`.
- R6: Bit 0 is held in a toggle cell. Its toggle input is high exactly when old `q[0]` differs from old `q[2]`.
- R7: After three consecutive rotations with no load, `q` returns to its starting value.
- R8: The patterns 3'b000 and 3'b111 are unchanged by rotation. The number of ones in `q` is never changed by rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| load | input | 1 | Synchronous parallel load enable |
| seed | input | 3 | Value written by a load |
| q | output | 3 | Current register contents |

## Verification
Every result of this block arrives one clock edge after the stimulus that causes it: a reset, a load or a single rotation. The bench drives its inputs on the falling edge and samples `q` on the next falling edge, half a period after the rising edge that updates it. The expected value comes from an arithmetic model of the rotation, `(v<<1 | v>>2) & 7`, applied once for each rising edge. The three-step return is checked by sampling exactly three edges after a load, for all eight seeds.

// File: rtl/rotl_pkg.sv
package rotl_pkg;
    localparam int unsigned WIDTH = 3;
    localparam int unsigned MSB   = WIDTH - 1;

    typedef logic [WIDTH-1:0] word_t;

    typedef enum logic [1:0] {
        OP_HOLD_RESET = 2'd0,
        OP_LOAD       = 2'd1,
        OP_ROTATE     = 2'd2
    } op_e;

    typedef struct packed {
        logic t_hi;
        logic d_mid;
        logic t_lo;
    } excite_t;

    function automatic word_t rotl1(input word_t v);
        return {v[MSB-1:0], v[MSB]};
    endfunction

    function automatic logic t_for(input logic now_v, input logic want_v);
        return now_v ^ want_v;
    endfunction
endpackage

// File: rtl/rotl_tcell.sv
module rotl_tcell (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic ld_val,
    input  logic t,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (ld)   q <= ld_val;
        else if (t)    q <= ~q;
    end
endmodule

// File: rtl/rotl_dcell.sv
module rotl_dcell (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic ld_val,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (ld)  q <= ld_val;
        else          q <= d;
    end
endmodule

// File: rtl/rotl_excite.sv
module rotl_excite
    import rotl_pkg::*;
(
    input  word_t   cur,
    output excite_t ex
);
    word_t want;
    always_comb begin
        want     = rotl1(cur);
        ex.t_hi  = t_for(cur[MSB], want[MSB]);
        ex.d_mid = want[1];
        ex.t_lo  = t_for(cur[0], want[0]);
    end
endmodule

// File: rtl/rotl_mixed.sv
module rotl_mixed
    import rotl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [2:0] seed,
    output logic [2:0] q
);
    word_t   cur;
    excite_t ex;
    op_e     op;

    always_comb begin
        if (rst)       op = OP_HOLD_RESET;
        else if (load) op = OP_LOAD;
        else           op = OP_ROTATE;
    end

    rotl_excite u_ex (.cur(cur), .ex(ex));

    rotl_tcell u_hi (.clk(clk), .rst(rst), .ld(op == OP_LOAD), .ld_val(seed[2]),
                     .t(ex.t_hi), .q(cur[2]));
    rotl_dcell u_mid (.clk(clk), .rst(rst), .ld(op == OP_LOAD), .ld_val(seed[1]),
                      .d(ex.d_mid), .q(cur[1]));
    rotl_tcell u_lo (.clk(clk), .rst(rst), .ld(op == OP_LOAD), .ld_val(seed[0]),
                     .t(ex.t_lo), .q(cur[0]));

    assign q = cur;

    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (q == 3'b000));
    a_r2_load_seed: assert property (@(posedge clk) past_ok && !rst && load |=> (q == $past(seed)));
    a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
        past_ok && !load |=> (q[2:1] == $past(q[1:0])));
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        past_ok && !load |=> (q[0] == $past(q[2])));
    a_r5_thi: assert property (@(posedge clk) disable iff (rst)
        past_ok && !load |=> ((q[2] != $past(q[2])) == $past(ex.t_hi)));
    a_r6_tlo: assert property (@(posedge clk) disable iff (rst)
        past_ok && !load |=> ((q[0] != $past(q[0])) == $past(ex.t_lo)));
    a_r8_ones: assert property (@(posedge clk) disable iff (rst)
        past_ok && !load |=> ($countones(q) == $countones($past(q))));
endmodule

// File: tb/test_rotl_mixed.sv
module test_rotl_mixed;
    logic clk = 1'b0;
    logic rst, load;
    logic [2:0] seed, q;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rotl_mixed i_rotl_mixed (.clk(clk), .rst(rst), .load(load), .seed(seed), .q(q));

    function automatic logic [2:0] model_rot(input logic [2:0] v);
        return ((v << 1) | (v >> 2)) & 3'b111;
    endfunction

    task automatic chk(input string req, input logic [2:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s q=%b expected=%b", req, q, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog q=%b expected=done", q);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; load = 0; seed = 3'b101;
        step(); step();
        chk("R1", 3'b000);
        rst = 0;
        step();
        chk("R8 zero fixed", 3'b000);
        for (int s = 0; s < 8; s++) begin
            logic [2:0] e, st, prev;
            seed = s[2:0]; load = 1;
            step();
            chk("R2", s[2:0]);
            load = 0;
            seed = ~s[2:0];
            st = s[2:0]; e = st;
            for (int k = 0; k < 3; k++) begin
                prev = e;
                e = model_rot(e);
                step();
                chk("R3", {e[2:1], q[0]});
                chk("R4", {q[2:1], e[0]});
                checks++;
                if ((q[2] != prev[2]) !== (prev[2] != prev[1])) begin
                    errors++; $display("FAIL R5 q=%b expected toggle=%b", q, prev[2]^prev[1]);
                end
                checks++;
                if ((q[0] != prev[0]) !== (prev[0] != prev[2])) begin
                    errors++; $display("FAIL R6 q=%b expected toggle=%b", q, prev[0]^prev[2]);
                end
                checks++;
                if ($countones(q) != $countones(prev)) begin
                    errors++; $display("FAIL R8 q=%b expected ones=%0d", q, $countones(prev));
                end
            end
            chk("R7", st);
        end
        seed = 3'b111; load = 1; step(); load = 0;
        step(); chk("R8 ones fixed", 3'b111);
        seed = 3'b001; load = 1; rst = 1; step();
        chk("R1 over load", 3'b000);
        rst = 0; load = 1; seed = 3'b100; step();
        seed = 3'b010; step();
        chk("R2 priority", 3'b010);
        load = 0; step();
        chk("R4", 3'b100);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule